// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block keeps the stores that are in flight in a circular queue, in program order. A store takes an entry when it is dispatched and receives an age tag back. Its address and its data are written later, as two separate operations that may come in either order. A store reaches the data cache only after it is retired at the head of the queue, and then only once both its address and its data are present.

A load searches the queue in the same cycle that it reads the data cache, so the result adds no extra cycle. The load carries the tag that the next store would have been given when the load was dispatched, so every store with a smaller tag is older than the load. Among the older stores whose address is known and equal to the load address, the load takes the one closest to it in program order. If that store has no data yet, the load gets a wait indication and not the stale cache value. If no older store matches, the load uses the cache data.

Tags are one bit wider than the entry index, and the top bit flips each time a pointer wraps. DEPTH must be a power of two. Allocation uses valid/ready: `alloc_ready` drops when the queue is full or when a flush is being applied. The cache write port uses valid/ready: the head stays in place until `dc_ready` accepts it, and `retire_ready` acknowledges the retirement in the same cycle. The address write, data write, load lookup and flush ports are always accepted and have no back-pressure.

Top module: `store_fwd_queue`

## Requirements
- R1: After reset the queue is empty, `alloc_ready` is 1, `alloc_tag` is 0, `dc_valid` stays 0 while `retire_valid` is high, and a load returns `ld_cache_data` with `ld_fwd`=0 and `ld_wait`=0.
- R2: Each accepted allocation returns `alloc_tag` = {wrap bit, index}, and the next tag is the current tag plus one, modulo 2*DEPTH. When DEPTH entries are held, `alloc_ready` is 0 and `alloc_valid` has no effect on `alloc_tag`.
- R3: The address write and the data write for an entry may come in either order. An entry takes part in matching only after its address has been written.
- R4: A load that has no older address-matching store returns `ld_cache_data` with `ld_fwd`=0 and `ld_wait`=0. Stores with a tag at or after `ld_age` are ignored.
- R5: When several older stores match, the load forwards the data of the one with the largest tag below `ld_age`, and sets `ld_fwd`=1.
- R6: If the nearest older matching store has no data yet, `ld_wait` is 1 and `ld_fwd` is 0, even if an older match does hold data. The two flags are never both 1.
- R7: The age search gives correct results when the occupied entries wrap past the last index, with tags crossing from index DEPTH-1 back to 0 and the wrap bit flipped.
- R8: `dc_valid` is 1 only when `retire_valid` is 1 and the head entry holds both its address and its data. It presents the head's address and data. A cycle with `dc_valid` and `dc_ready` both 1 removes the head and raises `retire_ready`.
- R9: With `flush_valid` high, the tail moves to `flush_tag`+1 and every younger entry is dropped. `alloc_ready` is 0 in that cycle, the next `alloc_tag` is `flush_tag`+1, and dropped stores no longer forward.
- R10: The lookup is combinational on the stored state. An address or data write shows in lookups from the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request for a new store entry |
| alloc_ready | output | 1 | An entry can be granted this cycle |
| alloc_tag | output | IW+1 | Tag granted to the next store |
| sta_valid | input | 1 | Store address write |
| sta_tag | input | IW+1 | Tag of the store taking the address |
| sta_addr | input | AW | Store address |
| std_valid | input | 1 | Store data write |
| std_tag | input | IW+1 | Tag of the store taking the data |
| std_data | input | DW | Store data |
| ld_valid | input | 1 | Load lookup |
| ld_age | input | IW+1 | Allocation tag current when the load was dispatched |
| ld_addr | input | AW | Load address |
| ld_cache_data | input | DW | Data read from the cache for the load |
| ld_fwd | output | 1 | Data is taken from a queued store |
| ld_wait | output | 1 | Nearest matching store has no data yet |
| ld_data | output | DW | Load result |
| retire_valid | input | 1 | Head store is being retired |
| retire_ready | output | 1 | Head store was written to the cache this cycle |
| dc_valid | output | 1 | Cache write request |
| dc_ready | input | 1 | Cache accepts the write |
| dc_addr | output | AW | Cache write address |
| dc_data | output | DW | Cache write data |
| flush_valid | input | 1 | Drop the entries younger than flush_tag |
| flush_tag | input | IW+1 | Youngest store that is kept |

## Verification
The bench fills an entry's data before its address and checks that the entry does not match until its address arrives. A design that matched on a stale address would forward the wrong store. Loads are placed between matching stores to show that the nearest older store wins and that younger stores are ignored. A search that ran from the wrong end, or that did not limit itself by age, would return the other store's data. A queue that has wrapped, with stores on both sides of index zero, checks the age ordering past the wrap. Order taken from the raw index would pick the entry before the wrap. The bench also checks a nearest match with no data while an older match holds data, a head without data that must not drain, and a flush followed by reallocation of the dropped slot. A design that kept the old flags in that slot would still forward the flushed store.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

  typedef enum logic [1:0] {
    LK_CACHE = 2'd0,
    LK_FWD   = 2'd1,
    LK_WAIT  = 2'd2
  } lk_kind_e;

  typedef struct packed {
    logic addr_ok;
    logic data_ok;
  } ent_flags_t;

endpackage

// File: rtl/sfq_ptr.sv
module sfq_ptr #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int TW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic          pop,
  input  logic          flush,
  input  logic [TW-1:0] flush_tag,
  output logic [TW-1:0] head_tag,
  output logic [TW-1:0] tail_tag,
  output logic [TW-1:0] count,
  output logic          full,
  output logic          empty
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_tag <= '0;
      tail_tag <= '0;
    end else begin
      if (pop) head_tag <= head_tag + TW'(1);
      if (flush) tail_tag <= flush_tag + TW'(1);
      else if (alloc_fire) tail_tag <= tail_tag + TW'(1);
    end
  end

  assign count = tail_tag - head_tag;
  assign full  = (count == TW'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/sfq_store.sv
module sfq_store #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_fire,
  input  logic [IW-1:0]         alloc_idx,
  input  logic                  sta_we,
  input  logic [IW-1:0]         sta_idx,
  input  logic [AW-1:0]         sta_addr,
  input  logic                  std_we,
  input  logic [IW-1:0]         std_idx,
  input  logic [DW-1:0]         std_data,
  output logic [AW-1:0]         addr_q  [DEPTH],
  output logic [DW-1:0]         data_q  [DEPTH],
  output sfq_pkg::ent_flags_t   flags_q [DEPTH]
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit_a, hit_d, hit_n;
    assign hit_a = sta_we && (sta_idx == IW'(i));
    assign hit_d = std_we && (std_idx == IW'(i));
    assign hit_n = alloc_fire && (alloc_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags_q[i] <= '0;
      end else if (hit_n) begin
        flags_q[i] <= '0;
      end else begin
        if (hit_a) flags_q[i].addr_ok <= 1'b1;
        if (hit_d) flags_q[i].data_ok <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_a) addr_q[i] <= sta_addr;
      if (hit_d) data_q[i] <= std_data;
    end
  end

endmodule

// File: rtl/sfq_search.sv
module sfq_search #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int TW = IW + 1
) (
  input  logic [TW-1:0]         head_tag,
  input  logic [TW-1:0]         count,
  input  logic [TW-1:0]         ld_age,
  input  logic [AW-1:0]         ld_addr,
  input  logic [AW-1:0]         addr_q  [DEPTH],
  input  sfq_pkg::ent_flags_t   flags_q [DEPTH],
  output sfq_pkg::lk_kind_e     kind,
  output logic [IW-1:0]         sel_idx
);

  logic [TW-1:0] ld_off;
  logic [IW-1:0] idx;
  logic          found;
  logic          sel_rdy;

  always_comb begin
    ld_off  = ld_age - head_tag;
    found   = 1'b0;
    sel_rdy = 1'b0;
    sel_idx = '0;
    idx     = '0;
    // walk from oldest to youngest; the last older match is the nearest
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_tag[IW-1:0] + IW'(k);
      if ((TW'(k) < ld_off) && (TW'(k) < count) &&
          flags_q[idx].addr_ok && (addr_q[idx] == ld_addr)) begin
        found   = 1'b1;
        sel_idx = idx;
        sel_rdy = flags_q[idx].data_ok;
      end
    end
    if (!found)       kind = sfq_pkg::LK_CACHE;
    else if (sel_rdy) kind = sfq_pkg::LK_FWD;
    else              kind = sfq_pkg::LK_WAIT;
  end

endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int TW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic [TW-1:0] alloc_tag,
  input  logic          sta_valid,
  input  logic [TW-1:0] sta_tag,
  input  logic [AW-1:0] sta_addr,
  input  logic          std_valid,
  input  logic [TW-1:0] std_tag,
  input  logic [DW-1:0] std_data,
  input  logic          ld_valid,
  input  logic [TW-1:0] ld_age,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_cache_data,
  output logic          ld_fwd,
  output logic          ld_wait,
  output logic [DW-1:0] ld_data,
  input  logic          retire_valid,
  output logic          retire_ready,
  output logic          dc_valid,
  input  logic          dc_ready,
  output logic [AW-1:0] dc_addr,
  output logic [DW-1:0] dc_data,
  input  logic          flush_valid,
  input  logic [TW-1:0] flush_tag
);

  logic [TW-1:0]       head_tag, tail_tag, occ;
  logic                full, empty, alloc_fire, pop, head_done;
  logic [IW-1:0]       head_idx, sel_idx;
  logic [AW-1:0]       addr_q  [DEPTH];
  logic [DW-1:0]       data_q  [DEPTH];
  sfq_pkg::ent_flags_t flags_q [DEPTH];
  sfq_pkg::lk_kind_e   kind;

  assign alloc_ready = !full && !flush_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_tag;

  assign head_idx  = head_tag[IW-1:0];
  assign head_done = !empty && flags_q[head_idx].addr_ok && flags_q[head_idx].data_ok;
  assign dc_valid  = retire_valid && head_done;
  assign dc_addr   = addr_q[head_idx];
  assign dc_data   = data_q[head_idx];
  assign pop       = dc_valid && dc_ready;
  assign retire_ready = pop;

  sfq_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .pop(pop),
    .flush(flush_valid), .flush_tag(flush_tag),
    .head_tag(head_tag), .tail_tag(tail_tag),
    .count(occ), .full(full), .empty(empty)
  );

  sfq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .alloc_idx(tail_tag[IW-1:0]),
    .sta_we(sta_valid), .sta_idx(sta_tag[IW-1:0]), .sta_addr(sta_addr),
    .std_we(std_valid), .std_idx(std_tag[IW-1:0]), .std_data(std_data),
    .addr_q(addr_q), .data_q(data_q), .flags_q(flags_q)
  );

  sfq_search #(.DEPTH(DEPTH), .AW(AW)) u_search (
    .head_tag(head_tag), .count(occ),
    .ld_age(ld_age), .ld_addr(ld_addr),
    .addr_q(addr_q), .flags_q(flags_q),
    .kind(kind), .sel_idx(sel_idx)
  );

  assign ld_fwd  = ld_valid && (kind == sfq_pkg::LK_FWD);
  assign ld_wait = ld_valid && (kind == sfq_pkg::LK_WAIT);
  assign ld_data = ld_fwd ? data_q[sel_idx] : ld_cache_data;

endmodule

// File: rtl/sfq_chk.sv
module sfq_chk #(
  parameter int DEPTH = 8,
  parameter int DW = 32,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [TW-1:0] alloc_tag,
  input logic [TW-1:0] occ,
  input logic          ld_valid,
  input logic          ld_fwd,
  input logic          ld_wait,
  input logic [DW-1:0] ld_data,
  input logic [DW-1:0] ld_cache_data,
  input logic          retire_valid,
  input logic          dc_valid,
  input logic          dc_ready,
  input logic          flush_valid,
  input logic [TW-1:0] flush_tag
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) occ <= TW'(DEPTH)); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) occ == TW'(DEPTH) |-> !alloc_ready); // R2
  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n) alloc_valid && alloc_ready |=> alloc_tag == $past(alloc_tag) + TW'(1)); // R2
  AST_MISS_CACHE: assert property (@(posedge clk) disable iff (!rst_n) ld_valid && !ld_fwd && !ld_wait |-> ld_data == ld_cache_data); // R4
  AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (!rst_n) ld_valid && occ == '0 |-> !ld_fwd && !ld_wait); // R4
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !(ld_fwd && ld_wait)); // R6
  AST_DRAIN_RETIRE: assert property (@(posedge clk) disable iff (!rst_n) dc_valid |-> retire_valid); // R8
  AST_DRAIN_POP: assert property (@(posedge clk) disable iff (!rst_n) dc_valid && dc_ready && !(alloc_valid && alloc_ready) && !flush_valid |=> occ == $past(occ) - TW'(1)); // R8
  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n) flush_valid |=> alloc_tag == $past(flush_tag) + TW'(1)); // R9
  AST_FLUSH_NOALLOC: assert property (@(posedge clk) disable iff (!rst_n) flush_valid |-> !alloc_ready); // R9

endmodule

bind store_fwd_queue sfq_chk #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
  .occ(occ),
  .ld_valid(ld_valid), .ld_fwd(ld_fwd), .ld_wait(ld_wait),
  .ld_data(ld_data), .ld_cache_data(ld_cache_data),
  .retire_valid(retire_valid), .dc_valid(dc_valid), .dc_ready(dc_ready),
  .flush_valid(flush_valid), .flush_tag(flush_tag)
);

// File: tb/store_fwd_queue_tb.sv
module store_fwd_queue_tb;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TW = 4;
  localparam logic [DW-1:0] CACHE = 32'hCAC0_0000;
  localparam logic [AW-1:0] A = 32'h0000_4000;
  localparam logic [AW-1:0] B = 32'h0000_4120;
  localparam logic [AW-1:0] C = 32'h0000_7700;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          alloc_valid, alloc_ready;
  logic [TW-1:0] alloc_tag;
  logic          sta_valid;
  logic [TW-1:0] sta_tag;
  logic [AW-1:0] sta_addr;
  logic          std_valid;
  logic [TW-1:0] std_tag;
  logic [DW-1:0] std_data;
  logic          ld_valid;
  logic [TW-1:0] ld_age;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_cache_data;
  logic          ld_fwd, ld_wait;
  logic [DW-1:0] ld_data;
  logic          retire_valid, retire_ready;
  logic          dc_valid, dc_ready;
  logic [AW-1:0] dc_addr;
  logic [DW-1:0] dc_data;
  logic          flush_valid;
  logic [TW-1:0] flush_tag;

  int n_chk = 0;
  int n_fail = 0;

  store_fwd_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .sta_valid(sta_valid), .sta_tag(sta_tag), .sta_addr(sta_addr),
    .std_valid(std_valid), .std_tag(std_tag), .std_data(std_data),
    .ld_valid(ld_valid), .ld_age(ld_age), .ld_addr(ld_addr), .ld_cache_data(ld_cache_data),
    .ld_fwd(ld_fwd), .ld_wait(ld_wait), .ld_data(ld_data),
    .retire_valid(retire_valid), .retire_ready(retire_ready),
    .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_addr(dc_addr), .dc_data(dc_data),
    .flush_valid(flush_valid), .flush_tag(flush_tag)
  );

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; sta_valid = 0; sta_tag = '0; sta_addr = '0;
    std_valid = 0; std_tag = '0; std_data = '0;
    ld_valid = 0; ld_age = '0; ld_addr = '0; ld_cache_data = CACHE;
    retire_valid = 0; dc_ready = 0; flush_valid = 0; flush_tag = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic alloc(output logic [TW-1:0] t);
    alloc_valid = 1;
    #1 t = alloc_tag;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic sta(logic [TW-1:0] t, logic [AW-1:0] a);
    sta_valid = 1; sta_tag = t; sta_addr = a;
    @(negedge clk);
    sta_valid = 0;
  endtask

  task automatic std(logic [TW-1:0] t, logic [DW-1:0] d);
    std_valid = 1; std_tag = t; std_data = d;
    @(negedge clk);
    std_valid = 0;
  endtask

  // result packed as {fwd, wait, data}
  task automatic look_chk(string req, logic [TW-1:0] age, logic [AW-1:0] a,
                          logic ef, logic ew, logic [DW-1:0] ed);
    ld_valid = 1; ld_age = age; ld_addr = a; ld_cache_data = CACHE;
    #1 chk(req, {ld_fwd, ld_wait, ld_data}, {ef, ew, ed});
    ld_valid = 0;
  endtask

  task automatic drain_chk(string req, logic ev, logic [AW-1:0] ea, logic [DW-1:0] ed);
    retire_valid = 1; dc_ready = 1;
    #1 chk(req, {dc_valid, retire_ready}, {ev, ev});
    if (ev) chk(req, {dc_addr, dc_data}, {ea, ed});
    @(negedge clk);
    retire_valid = 0; dc_ready = 0;
  endtask

  task automatic t_reset();
    do_reset();
    #1 chk("R1 ready/tag", {alloc_ready, alloc_tag}, {1'b1, 4'h0});
    drain_chk("R1 no drain", 1'b0, '0, '0);
    look_chk("R1 cache", 4'h0, A, 1'b0, 1'b0, CACHE);
  endtask

  task automatic t_fill();
    logic [TW-1:0] t;
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      alloc(t);
      chk("R2 tag", t, i);
    end
    #1 chk("R2 full", alloc_ready, 1'b0);
    alloc_valid = 1;
    @(negedge clk);
    alloc_valid = 0;
    #1 chk("R2 full no effect", alloc_tag, 4'h8);
  endtask

  task automatic t_forward();
    logic [TW-1:0] t;
    do_reset();
    repeat (3) alloc(t);
    std(4'h1, 32'hD1);
    look_chk("R3 data without addr", 4'h3, A, 1'b0, 1'b0, CACHE);
    sta_valid = 1; sta_tag = 4'h1; sta_addr = A;
    look_chk("R10 same cycle", 4'h3, A, 1'b0, 1'b0, CACHE);
    @(negedge clk);
    sta_valid = 0;
    look_chk("R3 addr after data", 4'h3, A, 1'b1, 1'b0, 32'hD1);
    sta(4'h2, A);
    look_chk("R6 nearest no data", 4'h3, A, 1'b0, 1'b1, CACHE);
    look_chk("R4 younger ignored", 4'h2, A, 1'b1, 1'b0, 32'hD1);
    sta(4'h0, A);
    std(4'h0, 32'hD0);
    look_chk("R5 nearest of two", 4'h2, A, 1'b1, 1'b0, 32'hD1);
    look_chk("R5 oldest only", 4'h1, A, 1'b1, 1'b0, 32'hD0);
    look_chk("R4 other addr", 4'h3, B, 1'b0, 1'b0, CACHE);
    drain_chk("R8 head 0", 1'b1, A, 32'hD0);
    drain_chk("R8 head 1", 1'b1, A, 32'hD1);
    drain_chk("R8 head no data", 1'b0, '0, '0);
    std(4'h2, 32'hD2);
    drain_chk("R8 head 2", 1'b1, A, 32'hD2);
    drain_chk("R8 empty", 1'b0, '0, '0);
    look_chk("R4 after drain", 4'h3, A, 1'b0, 1'b0, CACHE);
  endtask

  task automatic t_wrap();
    logic [TW-1:0] t;
    do_reset();
    for (int i = 0; i < 6; i++) begin
      alloc(t);
      sta(t, 32'h100 + i);
      std(t, i);
      drain_chk("R8 warmup", 1'b1, 32'h100 + i, i);
    end
    for (int i = 6; i < 10; i++) begin
      alloc(t);
      chk("R7 wrap tag", t, i);
    end
    sta(4'h6, B); std(4'h6, 32'hA6);
    sta(4'h8, B); std(4'h8, 32'hA8);
    sta(4'h9, C);
    look_chk("R7 across wrap", 4'hA, B, 1'b1, 1'b0, 32'hA8);
    look_chk("R7 before wrap", 4'h8, B, 1'b1, 1'b0, 32'hA6);
    look_chk("R7 skip other addr", 4'h9, B, 1'b1, 1'b0, 32'hA8);
    look_chk("R6 wait after wrap", 4'hA, C, 1'b0, 1'b1, CACHE);
    std(4'h9, 32'hA9);
    look_chk("R7 data arrives", 4'hA, C, 1'b1, 1'b0, 32'hA9);
  endtask

  task automatic t_flush();
    logic [TW-1:0] t;
    flush_valid = 1; flush_tag = 4'h7; alloc_valid = 1;
    #1 chk("R9 no alloc in flush", alloc_ready, 1'b0);
    @(negedge clk);
    flush_valid = 0; alloc_valid = 0;
    #1 chk("R9 tail rewound", alloc_tag, 4'h8);
    alloc(t);
    chk("R9 realloc tag", t, 4'h8);
    look_chk("R9 flushed store gone", 4'h9, B, 1'b1, 1'b0, 32'hA6);
    #1 chk("R9 next tag", alloc_tag, 4'h9);
  endtask

  initial begin
    rst_n = 0;
    idle();
    t_reset();
    t_fill();
    t_forward();
    t_wrap();
    t_flush();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    report();
  end

endmodule